// File: doc/BRIEF.md
# Ingress Datagram Preprocessing Unit

This block sits between a group of line-card receive buffers and the shared data memory of a packet processor. It polls the buffers in rotating order. When one of them reports a complete datagram, the unit copies every word of it into memory, header and payload alike, because a variable chain of extension headers may follow the fixed header. Each word goes to the next address of a circular write region. When the last word is written, the unit queues a descriptor that pairs the datagram's start address with the index of the port it came from.

The central controller collects descriptors through a transport-triggered register interface. That interface has one trigger register and two result registers. A single flag tells the controller that at least one descriptor is waiting. A write to the trigger pops the oldest descriptor into the two result registers. A pop while nothing is queued leaves the results alone and sets an error flag that stays set.

Top module: `ingress_prep_unit`

## Requirements
- R1: During and right after reset, `pending`, `popError`, `memWe` and every `portRead` bit are 0, and `resAddr` and `resPort` are 0.
- R2: An accepted datagram of length L is written over exactly L consecutive cycles, starting the cycle after acceptance. There is one memory write per cycle, to consecutive addresses modulo 2^ADDR_W. Word k of the source port appears on `memWdata` in write k. The `portRead` bit of that port alone is high in each of those cycles, and no `portRead` bit is high in any other cycle.
- R3: The write pointer is 0 after reset. Each datagram starts at the current pointer, and the pointer then advances by the datagram's length, wrapping modulo 2^ADDR_W.
- R4: In the cycle of a datagram's last word write, a descriptor {start address, port index} is appended to the queue.
- R5: `pending` is 1 exactly when the queue holds at least one descriptor. It first shows a new descriptor in the cycle after that descriptor's last word write.
- R6: When `trigWr` is sampled high with the queue not empty, the oldest descriptor is removed. In the next cycle `resAddr` holds its start address and `resPort` holds its port index. Descriptors leave in the order they were queued.
- R7: When idle, the unit grants the first port with `portValid` high, searching in increasing index order. The search starts one past the port serviced last and wraps around, so port 0 is searched first after reset.
- R8: While the queue holds DEPTH descriptors, no datagram is accepted: `memWe` and `portRead` stay 0 until a pop frees a slot.
- R9: A `trigWr` sampled while the queue is empty leaves `resAddr` and `resPort` unchanged and sets `popError` from the next cycle. `popError` then stays 1 until reset.
- R10: The length field of the granted port is sampled in the acceptance cycle. Every length from 1 to 2^LEN_W-1 is handled, the extremes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| portValid | input | NUM_PORTS | Per-port flag: a datagram is ready |
| portLen | input | NUM_PORTS*LEN_W | Per-port datagram length in words, port p at bits [p*LEN_W +: LEN_W] |
| portData | input | NUM_PORTS*DATA_W | Per-port current word, port p at bits [p*DATA_W +: DATA_W] |
| portRead | output | NUM_PORTS | Per-port strobe: current word consumed at this edge |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| trigWr | input | 1 | Trigger register write: pop one descriptor |
| resAddr | output | ADDR_W | Result register 0: start address of popped datagram |
| resPort | output | PORT_W | Result register 1: source port of popped datagram |
| pending | output | 1 | Descriptors are waiting |
| popError | output | 1 | Sticky flag: pop was attempted on an empty queue |

## Verification
The bench builds the unit with three ports, a 64-word region, 4-bit lengths and a four-entry queue. The odd port count exercises the wrapping arbiter search where it does not align with a power of two. The small region makes the write pointer wrap many times within a few thousand cycles. The shallow queue fills quickly, which brings the acceptance stall and the pop on an empty queue into reach. Directed phases force one-word and fifteen-word datagrams. Random phases mix injections with pops so that a push and a pop often land in the same cycle.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

  // Control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic accept;  // a datagram was granted this cycle
    logic wordWr;  // one word moves to memory this cycle
    logic push;    // last word this cycle: queue the descriptor
  } ipuStrobe_t;

endpackage

// File: rtl/ipu_ctrl.sv
module ipu_ctrl
  import ipu_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LEN_W     = 6,
  parameter int DEPTH     = 8,
  parameter int PORT_W    = 2,
  parameter int CNT_W     = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PORTS-1:0]       portValid,
  input  logic [NUM_PORTS*LEN_W-1:0] portLen,
  input  logic [CNT_W-1:0]           fifoCount,
  output logic [NUM_PORTS-1:0]       portRead,
  output ipuStrobe_t                 stb,
  output logic [PORT_W-1:0]          selPort,
  output logic [LEN_W-1:0]           selLen
);

  typedef enum logic {S_IDLE, S_XFER} ctrlState_t;

  ctrlState_t        state;
  logic [PORT_W-1:0] lastPort;
  logic [LEN_W-1:0]  remain;
  logic              anyGrant;
  logic [PORT_W-1:0] grantIdx;
  logic [LEN_W-1:0]  grantLen;
  logic              fifoFull;
  logic              lastWord;

  assign fifoFull = (fifoCount == CNT_W'(DEPTH));
  assign lastWord = (remain == '0);

  // Rotating search: first valid port after the one serviced last
  always_comb begin
    anyGrant = 1'b0;
    grantIdx = '0;
    for (int k = 1; k <= NUM_PORTS; k++) begin
      int cand;
      cand = (int'(lastPort) + k) % NUM_PORTS;
      if (!anyGrant && portValid[cand]) begin
        anyGrant = 1'b1;
        grantIdx = PORT_W'(cand);
      end
    end
  end

  assign grantLen = portLen[int'(grantIdx)*LEN_W +: LEN_W];

  always_comb begin
    stb.accept = (state == S_IDLE) && anyGrant && !fifoFull;
    stb.wordWr = (state == S_XFER);
    stb.push   = (state == S_XFER) && lastWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      lastPort <= PORT_W'(NUM_PORTS - 1);
      selPort  <= '0;
      selLen   <= '0;
      remain   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (stb.accept) begin
            state   <= S_XFER;
            selPort <= grantIdx;
            selLen  <= grantLen;
            remain  <= grantLen - 1'b1;
          end
        end
        S_XFER: begin
          if (lastWord) begin
            state    <= S_IDLE;
            lastPort <= selPort;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // One read strobe per port, decoded from the selected index
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_readDec
    assign portRead[g] = (state == S_XFER) && (selPort == PORT_W'(g));
  end

endmodule

// File: rtl/ipu_datapath.sv
module ipu_datapath
  import ipu_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 10,
  parameter int LEN_W     = 6,
  parameter int DEPTH     = 8,
  parameter int PORT_W    = 2,
  parameter int CNT_W     = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ipuStrobe_t                  stb,
  input  logic [PORT_W-1:0]           selPort,
  input  logic [LEN_W-1:0]            selLen,
  input  logic [NUM_PORTS*DATA_W-1:0] portData,
  input  logic                        trigWr,
  output logic                        memWe,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [DATA_W-1:0]           memWdata,
  output logic [CNT_W-1:0]            fifoCount,
  output logic [ADDR_W-1:0]           resAddr,
  output logic [PORT_W-1:0]           resPort,
  output logic                        pending,
  output logic                        popError
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] offset;

  logic [ADDR_W-1:0] descAddr [DEPTH];
  logic [PORT_W-1:0] descPort [DEPTH];
  logic [IDX_W-1:0]  headIdx;
  logic [IDX_W-1:0]  tailIdx;
  logic              popOk;
  logic              popEmpty;

  function automatic logic [IDX_W-1:0] bumpIdx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  // Word movement
  assign memWe    = stb.wordWr;
  assign memAddr  = baseAddr + offset;
  assign memWdata = portData[int'(selPort)*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      baseAddr <= '0;
      offset   <= '0;
    end else begin
      if (stb.accept) begin
        baseAddr <= wrPtr;
        offset   <= '0;
      end else if (stb.wordWr) begin
        offset <= offset + 1'b1;
      end
      if (stb.push) wrPtr <= wrPtr + ADDR_W'(selLen);
    end
  end

  // Descriptor queue
  assign popOk    = trigWr && (fifoCount != '0);
  assign popEmpty = trigWr && (fifoCount == '0);
  assign pending  = (fifoCount != '0);

  always_ff @(posedge clk) begin
    if (stb.push) begin
      descAddr[tailIdx] <= baseAddr;
      descPort[tailIdx] <= selPort;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx   <= '0;
      tailIdx   <= '0;
      fifoCount <= '0;
      resAddr   <= '0;
      resPort   <= '0;
      popError  <= 1'b0;
    end else begin
      if (stb.push) tailIdx <= bumpIdx(tailIdx);
      if (popOk) begin
        headIdx <= bumpIdx(headIdx);
        resAddr <= descAddr[headIdx];
        resPort <= descPort[headIdx];
      end
      if (popEmpty) popError <= 1'b1;
      case ({stb.push, popOk})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: fifoCount <= fifoCount;
      endcase
    end
  end

endmodule

// File: rtl/ingress_prep_unit.sv
module ingress_prep_unit
  import ipu_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 10,
  parameter int LEN_W     = 6,
  parameter int DEPTH     = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        portValid,
  input  logic [NUM_PORTS*LEN_W-1:0]  portLen,
  input  logic [NUM_PORTS*DATA_W-1:0] portData,
  output logic [NUM_PORTS-1:0]        portRead,
  output logic                        memWe,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [DATA_W-1:0]           memWdata,
  input  logic                        trigWr,
  output logic [ADDR_W-1:0]           resAddr,
  output logic [PORT_W-1:0]           resPort,
  output logic                        pending,
  output logic                        popError
);

  ipuStrobe_t        stb;
  logic [PORT_W-1:0] selPort;
  logic [LEN_W-1:0]  selLen;
  logic [CNT_W-1:0]  fifoCount;

  ipu_ctrl #(
    .NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W), .DEPTH(DEPTH),
    .PORT_W(PORT_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .portValid(portValid), .portLen(portLen),
    .fifoCount(fifoCount), .portRead(portRead), .stb(stb),
    .selPort(selPort), .selLen(selLen)
  );

  ipu_datapath #(
    .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .DEPTH(DEPTH), .PORT_W(PORT_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .selPort(selPort), .selLen(selLen),
    .portData(portData), .trigWr(trigWr), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .fifoCount(fifoCount), .resAddr(resAddr),
    .resPort(resPort), .pending(pending), .popError(popError)
  );

endmodule

// File: rtl/ingress_prep_unit_chk.sv
module ingress_prep_unit_chk
  import ipu_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 10,
  parameter int DEPTH     = 8,
  parameter int PORT_W    = 2,
  parameter int CNT_W     = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] portRead,
  input logic                 memWe,
  input logic [ADDR_W-1:0]    memAddr,
  input logic                 trigWr,
  input logic [ADDR_W-1:0]    resAddr,
  input logic [PORT_W-1:0]    resPort,
  input logic                 pending,
  input logic                 popError,
  input logic [CNT_W-1:0]     fifoCount,
  input ipuStrobe_t           stb
);

  assert_one_reader_R2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $countones(portRead) == 1);

  assert_read_only_writing_R2: assert property (@(posedge clk) disable iff (!rstN)
    (portRead != '0) |-> memWe);

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> memAddr == $past(memAddr) + 1'b1);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == CNT_W'(DEPTH)) |-> !stb.push);

  assert_no_accept_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == CNT_W'(DEPTH)) |-> !stb.accept);

  assert_pending_after_push_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(stb.push));

  assert_empty_pop_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (trigWr && fifoCount == '0) |=> ($stable(resAddr) && $stable(resPort) && popError));

  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    popError |=> popError);

endmodule

bind ingress_prep_unit ingress_prep_unit_chk #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DEPTH(DEPTH),
  .PORT_W(PORT_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .portRead(portRead), .memWe(memWe),
  .memAddr(memAddr), .trigWr(trigWr), .resAddr(resAddr), .resPort(resPort),
  .pending(pending), .popError(popError), .fifoCount(fifoCount), .stb(stb)
);

// File: tb/ingress_prep_unit_tb_top.sv
module ingress_prep_unit_tb_top;

  localparam int NP    = 3;
  localparam int DW    = 32;
  localparam int AW    = 6;
  localparam int LW    = 4;
  localparam int DEPTH = 4;
  localparam int PW    = 2;
  localparam int REGION = 1 << AW;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NP-1:0]      portValid = '0;
  logic [NP*LW-1:0]   portLen = '0;
  logic [NP*DW-1:0]   portData = '0;
  logic [NP-1:0]      portRead;
  logic               memWe;
  logic [AW-1:0]      memAddr;
  logic [DW-1:0]      memWdata;
  logic               trigWr = 1'b0;
  logic [AW-1:0]      resAddr;
  logic [PW-1:0]      resPort;
  logic               pending;
  logic               popError;

  always #10 clk = ~clk;

  ingress_prep_unit #(
    .NUM_PORTS(NP), .DATA_W(DW), .ADDR_W(AW), .LEN_W(LW), .DEPTH(DEPTH)
  ) dut_i (
    .clk(clk), .rstN(rstN), .portValid(portValid), .portLen(portLen),
    .portData(portData), .portRead(portRead), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .trigWr(trigWr), .resAddr(resAddr), .resPort(resPort),
    .pending(pending), .popError(popError)
  );

  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit finished = 0;

  // Line-card model
  int pendCnt [NP];
  int curLen  [NP];
  int wIdx    [NP];
  int seqNo   [NP];
  int injReq  [NP];
  int forceLen = 0;
  int popMode  = 0;  // 0 none, 1 random, 2 single, 3 always

  // Expected-state model
  int expPtr = 0;
  int lastPortB = NP - 1;
  bit inXfer = 0;
  int curP, curBase, curOff, curLenB;
  int qB [1024];
  int qP [1024];
  int qHead = 0, qTail = 0;
  bit popPending = 0, popWasEmpty = 0;
  int popExpBase, popExpPort;
  bit expErr = 0;
  int prevRes0 = 0, prevRes1 = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] wordOf(input int p, input int s, input int i);
    return {8'(p), 8'(s), 16'(i)};
  endfunction

  function automatic int newLen();
    if (forceLen != 0) return forceLen;
    return int'($urandom_range(15, 1));
  endfunction

  function automatic int rrPick(input int last, input logic [NP-1:0] v);
    for (int k = 1; k <= NP; k++) begin
      int c;
      c = (last + k) % NP;
      if (v[c]) return c;
    end
    return -1;
  endfunction

  task automatic drivePorts();
    for (int p = 0; p < NP; p++) begin
      portValid[p] = (pendCnt[p] > 0);
      portLen[p*LW +: LW] = LW'(curLen[p]);
      portData[p*DW +: DW] = wordOf(p, seqNo[p], wIdx[p]);
    end
  endtask

  // Per-cycle checking and driving, all at the falling edge
  initial begin
    wait (running);
    while (running) begin
      @(negedge clk);
      begin
        int sizeNow;
        bit doPop;
        sizeNow = qTail - qHead;

        if (popPending) begin
          if (popWasEmpty) begin
            check(resAddr == AW'(prevRes0) && resPort == PW'(prevRes1),
                  "R9 results held on empty pop", int'(resAddr), prevRes0);
          end else begin
            check(resAddr == AW'(popExpBase), "R6 resAddr", int'(resAddr), popExpBase);
            check(resPort == PW'(popExpPort), "R6 resPort", int'(resPort), popExpPort);
          end
          prevRes0 = int'(resAddr);
          prevRes1 = int'(resPort);
          popPending = 0;
        end

        check(pending == (sizeNow > 0), "R5 pending", int'(pending), int'(sizeNow > 0));
        check(popError == expErr, "R9 popError", int'(popError), int'(expErr));

        if (sizeNow == DEPTH && !inXfer)
          check(!memWe && portRead == '0, "R8 stall while full", int'(memWe), 0);

        if (memWe) begin
          if (!inXfer) begin
            int e;
            e = rrPick(lastPortB, portValid);
            check(e >= 0, "R7 grant needs a valid port", e, 0);
            if (e < 0) e = 0;
            curP = e;
            curBase = expPtr;
            curOff = 0;
            curLenB = curLen[e];
            inXfer = 1;
          end
          check(portRead == NP'(1 << curP), "R7 R2 read strobe", int'(portRead), 1 << curP);
          check(memAddr == AW'((curBase + curOff) % REGION), "R2 R3 address",
                int'(memAddr), (curBase + curOff) % REGION);
          check(memWdata == wordOf(curP, seqNo[curP], curOff), "R2 R10 word",
                int'(memWdata), int'(wordOf(curP, seqNo[curP], curOff)));
          if (curOff == curLenB - 1) begin
            qB[qTail % 1024] = curBase;  // R4 descriptor contents
            qP[qTail % 1024] = curP;
            qTail++;
            expPtr = (expPtr + curLenB) % REGION;
            lastPortB = curP;
            inXfer = 0;
          end else begin
            curOff++;
          end
        end else begin
          check(portRead == '0, "R2 no read without write", int'(portRead), 0);
        end

        // Advance the line-card model
        for (int p = 0; p < NP; p++) begin
          if (portRead[p]) begin
            if (wIdx[p] == curLen[p] - 1) begin
              wIdx[p] = 0;
              seqNo[p] = (seqNo[p] + 1) % 256;
              pendCnt[p]--;
              curLen[p] = newLen();
            end else begin
              wIdx[p]++;
            end
          end
          pendCnt[p] += injReq[p];
          injReq[p] = 0;
        end

        case (popMode)
          1: doPop = ($urandom_range(99, 0) < 40);
          2: begin doPop = 1; popMode = 0; end
          3: doPop = 1;
          default: doPop = 0;
        endcase
        if (doPop) begin
          trigWr = 1'b1;
          popPending = 1;
          if (sizeNow == 0) begin
            popWasEmpty = 1;
            expErr = 1;
          end else begin
            popWasEmpty = 0;
            popExpBase = qB[qHead % 1024];
            popExpPort = qP[qHead % 1024];
            qHead++;
          end
        end else begin
          trigWr = 1'b0;
        end
        drivePorts();
      end
    end
  end

  // Stimulus sequence
  initial begin
    void'($urandom(32'h1b7e_40c3));
    forceLen = 1;
    for (int p = 0; p < NP; p++) begin
      pendCnt[p] = 0; wIdx[p] = 0; seqNo[p] = p * 17; injReq[p] = 0;
      curLen[p] = newLen();
    end
    drivePorts();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pending == 1'b0, "R1 pending", int'(pending), 0);
    check(popError == 1'b0, "R1 popError", int'(popError), 0);
    check(memWe == 1'b0 && portRead == '0, "R1 no transfer", int'(memWe), 0);
    check(resAddr == '0 && resPort == '0, "R1 results", int'(resAddr), 0);
    @(posedge clk);
    rstN = 1'b1;
    running = 1;

    // Pop on an empty queue (R9)
    repeat (2) @(posedge clk);
    popMode = 2;
    repeat (5) @(posedge clk);

    // One-word datagrams on all ports at once: rotation from port 0 (R7, R10)
    for (int p = 0; p < NP; p++) injReq[p] = 1;
    repeat (20) @(posedge clk);

    // Fifteen-word datagrams, no pops: queue fills and polling stalls (R8)
    forceLen = 15;
    for (int p = 0; p < NP; p++) curLen[p] = 15;
    for (int p = 0; p < NP; p++) injReq[p] = 3;
    repeat (150) @(posedge clk);

    // Random mix of lengths, injections and pops
    forceLen = 0;
    popMode = 1;
    for (int c = 0; c < 3000; c++) begin
      @(posedge clk);
      if ($urandom_range(99, 0) < 12) injReq[$urandom_range(NP - 1, 0)] = 1;
    end

    // Drain, then keep popping on empty
    repeat (1500) @(posedge clk);
    popMode = 3;
    repeat (300) @(posedge clk);
    popMode = 0;
    repeat (5) @(posedge clk);
    running = 0;
    @(negedge clk);
    check(qTail > 20, "R4 enough descriptors produced", qTail, 21);
    check(qTail == qHead, "R6 queue drained", qHead, qTail);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule